// File: doc/BRIEF.md
# E1 Basic Frame Alignment Searcher

This block takes the received 2.048 Mb/s E1 bit stream one bit at a time, each bit qualified by a bit-clock enable. It finds where the 256-bit frame starts and tracks that position. A frame is 32 timeslots of 8 bits each. Even frames carry the seven-bit alignment word in timeslot 0, and odd frames carry the non-alignment content there.

While hunting, the block slides a seven-bit window over the stream. When the window matches, that spot becomes a candidate and the position counters are loaded from it. The candidate then has to pass two further tests. First, bit 2 of timeslot 0 in the following odd frame must be one. Second, the alignment word must appear again at the expected place in the next even frame. Only after both tests does the block declare sync. Once in sync, it drops back to hunting after three alignment words in a row are received in error.

The block drives an active-low sync flag, the bit index within the timeslot, the timeslot index and an odd-frame flag. Multiframe searchers placed after this block use these outputs to locate their own fields.

Top module: `e1_frame_align`

## Requirements
- R1: After a synchronous reset, `sync_n` is 1, `bit_idx` is 0, `ts_idx` is 0, `frame_odd` is 0, and the block is hunting. The seven-bit window holds all ones after reset, so bits that were never received cannot form a match.
- R2: A clock cycle with `bit_en` low changes none of the outputs, whatever the value on `rx_bit`.
- R3: While hunting, the block checks each received bit. If that bit and the six bits before it, oldest first, equal 0011011, the received bit is taken as bit 8 of timeslot 0 in an even frame. The block then reports `bit_idx`=7, `ts_idx`=0 and `frame_odd`=0 for that bit.
- R4: After a candidate, the block examines the second bit of timeslot 0 in the next odd frame (`bit_idx`=1, `frame_odd`=1). If that bit is 0, the candidate is dropped and hunting resumes with the next received bit. The next even-frame alignment word is then only a new candidate and does not declare sync.
- R5: If that odd-frame bit is 1, and the seven bits ending at `bit_idx`=7 of the next even frame equal 0011011, sync is declared. `sync_n` falls on the edge that consumes that seventh bit. If the word is wrong, hunting resumes.
- R6: `sync_n` is active low. It is 0 exactly while basic frame alignment is held.
- R7: Bit index 0 is the first bit of a timeslot. `bit_idx` counts 0 to 7 and `ts_idx` counts 0 to 31. `frame_odd` toggles when the count wraps from timeslot 31, bit 7 to timeslot 0, bit 0. The counters keep running in every state.
- R8: In sync, each even-frame alignment word is compared with 0011011 at `bit_idx`=7. A correct word clears the error count. `sync_n` rises on the edge that consumes the third errored word in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `rx_bit` for one bit period |
| rx_bit | input | 1 | Received serial line bit |
| sync_n | output | 1 | 0 while basic frame alignment is held |
| bit_idx | output | 3 | Position of the last received bit within its timeslot |
| ts_idx | output | 5 | Timeslot of the last received bit |
| frame_odd | output | 1 | 1 when the last received bit lies in an odd (non-alignment) frame |

## Verification
Every output is a register updated on the edge that consumes a qualified bit, so each result is due one clock after the bit is driven. The bench drives a bit at the falling edge and reads the outputs two time units after the next rising edge, before it drives anything more. It also compares the outputs with a behavioural model at every falling edge, including the idle cycles with `bit_en` low. Scenario checks sample `sync_n` on both sides of the deciding bit: bit 7 of the confirming alignment word, and bit 7 of the third errored word. This confirms the change falls on exactly that bit.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_NFAS    = 2'd1,
    ST_CONFIRM = 2'd2,
    ST_LOCK    = 2'd3
  } fa_state_t;
endpackage

// File: rtl/fa_window.sv
module fa_window #(
  parameter int                 FAS_LEN  = 7,
  parameter logic [FAS_LEN-1:0] FAS_WORD = 7'b0011011
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_bit,
  output logic hit
);
  logic [FAS_LEN-2:0] hist;

  // history starts at all ones so no partial fill can match
  always_ff @(posedge clk) begin
    if (rst)         hist <= '1;
    else if (bit_en) hist <= {hist[FAS_LEN-3:0], rx_bit};
  end

  assign hit = ({hist, rx_bit} == FAS_WORD);
endmodule

// File: rtl/fa_counter.sv
module fa_counter #(
  parameter int FRAME_BITS = 256,
  parameter int FAS_END    = 7,
  localparam int PW        = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          load,
  output logic [PW-1:0] pos,
  output logic          odd,
  output logic          at_fas,
  output logic          at_nfas_b2
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  logic [PW-1:0] nxt_pos;
  logic          nxt_odd;

  assign nxt_pos    = (pos == LAST) ? '0 : pos + 1'b1;
  assign nxt_odd    = odd ^ (pos == LAST);
  assign at_fas     = (nxt_pos == PW'(FAS_END)) && !nxt_odd;
  assign at_nfas_b2 = (nxt_pos == PW'(1)) && nxt_odd;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      odd <= 1'b0;
    end else if (bit_en) begin
      if (load) begin
        pos <= PW'(FAS_END);
        odd <= 1'b0;
      end else begin
        pos <= nxt_pos;
        odd <= nxt_odd;
      end
    end
  end

  // R2
  hold_pos_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(pos) && $stable(odd)));

  // R3
  load_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && load) |=> (pos == PW'(FAS_END) && !odd));

  // R7
  odd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(odd) |-> ($past(pos) == LAST || $past(load)));
endmodule

// File: rtl/fa_fsm.sv
module fa_fsm
  import fa_pkg::*;
#(
  parameter int LOSS_COUNT = 3,
  localparam int EW        = $clog2(LOSS_COUNT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic hit,
  input  logic at_fas,
  input  logic at_nfas_b2,
  output logic load,
  output logic sync_n
);
  fa_state_t     state, nstate;
  logic [EW-1:0] err, nerr;

  always_comb begin
    nstate = state;
    nerr   = err;
    load   = 1'b0;
    if (bit_en) begin
      unique case (state)
        ST_HUNT: begin
          if (hit) begin
            load   = 1'b1;
            nstate = ST_NFAS;
          end
        end
        ST_NFAS: begin
          if (at_nfas_b2) nstate = rx_bit ? ST_CONFIRM : ST_HUNT;
        end
        ST_CONFIRM: begin
          if (at_fas) nstate = hit ? ST_LOCK : ST_HUNT;
        end
        ST_LOCK: begin
          if (at_fas) begin
            if (hit) nerr = '0;
            else if (err == EW'(LOSS_COUNT - 1)) begin
              nerr   = '0;
              nstate = ST_HUNT;
            end else nerr = err + 1'b1;
          end
        end
        default: nstate = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_HUNT;
      err    <= '0;
      sync_n <= 1'b1;
    end else begin
      state  <= nstate;
      err    <= nerr;
      sync_n <= (nstate != ST_LOCK);
    end
  end

  // R5
  sync_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |-> ($past(state) == ST_CONFIRM && $past(at_fas) && $past(hit)));

  // R8
  sync_loss_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> ($past(err) == EW'(LOSS_COUNT - 1) && $past(at_fas) && !$past(hit)));

  // R8
  err_range_chk: assert property (@(posedge clk) disable iff (rst)
    err < EW'(LOSS_COUNT));

  // R6
  sync_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_n) |-> (state == ST_LOCK));
endmodule

// File: rtl/e1_frame_align.sv
module e1_frame_align #(
  parameter int                 TS_BITS    = 8,
  parameter int                 NUM_TS     = 32,
  parameter int                 FAS_LEN    = 7,
  parameter logic [FAS_LEN-1:0] FAS_WORD   = 7'b0011011,
  parameter int                 LOSS_COUNT = 3,
  localparam int                BIT_W      = $clog2(TS_BITS),
  localparam int                TS_W       = $clog2(NUM_TS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             rx_bit,
  output logic             sync_n,
  output logic [BIT_W-1:0] bit_idx,
  output logic [TS_W-1:0]  ts_idx,
  output logic             frame_odd
);
  localparam int FRAME_BITS = TS_BITS * NUM_TS;
  localparam int PW         = $clog2(FRAME_BITS);
  localparam int FAS_END    = FAS_LEN;

  logic          hit, load, at_fas, at_nfas_b2;
  logic [PW-1:0] pos;

  fa_window #(.FAS_LEN(FAS_LEN), .FAS_WORD(FAS_WORD)) u_window (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .hit(hit)
  );

  fa_counter #(.FRAME_BITS(FRAME_BITS), .FAS_END(FAS_END)) u_counter (
    .clk(clk), .rst(rst), .bit_en(bit_en), .load(load),
    .pos(pos), .odd(frame_odd), .at_fas(at_fas), .at_nfas_b2(at_nfas_b2)
  );

  fa_fsm #(.LOSS_COUNT(LOSS_COUNT)) u_fsm (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .hit(hit),
    .at_fas(at_fas), .at_nfas_b2(at_nfas_b2), .load(load), .sync_n(sync_n)
  );

  assign bit_idx = pos[BIT_W-1:0];
  assign ts_idx  = pos[PW-1:BIT_W];
endmodule

// File: tb/e1_frame_align_tb_top.sv
module e1_frame_align_tb_top;
  logic       clk = 1'b0;
  logic       rst, bit_en, rx_bit;
  logic       sync_n, frame_odd;
  logic [2:0] bit_idx;
  logic [4:0] ts_idx;

  always #4 clk = ~clk;

  e1_frame_align dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .sync_n(sync_n), .bit_idx(bit_idx), .ts_idx(ts_idx), .frame_odd(frame_odd)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit gap      = 0;
  bit done     = 0;

  // behavioural reference: 0 hunt, 1 await odd bit, 2 confirm, 3 locked
  int m_pos, m_odd, m_state, m_err;
  bit hist[$];

  function automatic void m_reset();
    m_pos = 0; m_odd = 0; m_state = 0; m_err = 0;
    hist = {};
    for (int i = 0; i < 6; i++) hist.push_back(1'b1);
  endfunction

  function automatic bit m_match(bit b);
    bit [6:0] w;
    for (int i = 0; i < 6; i++) w[6-i] = hist[i];
    w[0] = b;
    return w == 7'b0011011;
  endfunction

  function automatic void m_step(bit b);
    bit win;
    int npos, nodd;
    win  = m_match(b);
    npos = (m_pos + 1) % 256;
    nodd = (m_pos == 255) ? 1 - m_odd : m_odd;
    if (m_state == 0) begin
      if (win) begin npos = 7; nodd = 0; m_state = 1; end
    end else if (m_state == 1) begin
      if (npos == 1 && nodd == 1) m_state = b ? 2 : 0;
    end else if (m_state == 2) begin
      if (npos == 7 && nodd == 0) m_state = win ? 3 : 0;
    end else begin
      if (npos == 7 && nodd == 0) begin
        if (win) m_err = 0;
        else begin
          m_err++;
          if (m_err == 3) begin m_err = 0; m_state = 0; end
        end
      end
    end
    m_pos = npos; m_odd = nodd;
    hist.push_back(b);
    void'(hist.pop_front());
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(req, "sync_n vs model (R6)", int'(sync_n), (m_state == 3) ? 0 : 1);
    check(req, "bit_idx vs model (R7)", int'(bit_idx), m_pos % 8);
    check(req, "ts_idx vs model (R7)", int'(ts_idx), m_pos / 8);
    check(req, "frame_odd vs model (R7)", int'(frame_odd), m_odd);
  endtask

  task automatic send_bit(bit b);
    @(negedge clk);
    compare_all("R7");
    rx_bit = b;
    bit_en = 1'b1;
    m_step(b);
    @(posedge clk);
    #2;
    bit_en = 1'b0;
    rx_bit = ~b;
    if (gap) begin
      @(negedge clk);
      compare_all("R2");
      @(posedge clk);
      #2;
    end
  endtask

  function automatic bit frame_bit(bit fas, bit good, bit b2, int p);
    bit [6:0] w;
    if (p >= 8 || p == 0) return 1'b1;
    if (fas) begin
      w = 7'b0011011;
      if (!good) w[3] = ~w[3];
      return w[7-p];
    end
    if (p == 1) return b2;
    if (p == 2) return 1'b0;
    return 1'b1;
  endfunction

  task automatic send_range(bit fas, bit good, bit b2, int lo, int hi);
    for (int p = lo; p <= hi; p++) send_bit(frame_bit(fas, good, b2, p));
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0; rx_bit = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    m_reset();
    @(posedge clk);
    #2;
    check("R1", "sync_n after reset", int'(sync_n), 1);
    check("R1", "bit_idx after reset", int'(bit_idx), 0);
    check("R1", "ts_idx after reset", int'(ts_idx), 0);
    check("R1", "frame_odd after reset", int'(frame_odd), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // Scenario A: clean acquisition, then error counting and loss
    gap = 0;
    do_reset();
    send_range(1, 1, 1, 0, 7);
    check("R3", "bit_idx at candidate", int'(bit_idx), 7);
    check("R3", "ts_idx at candidate", int'(ts_idx), 0);
    check("R3", "sync_n at candidate", int'(sync_n), 1);
    send_range(1, 1, 1, 8, 255);
    send_range(0, 1, 1, 0, 255);
    check("R7", "ts_idx end of odd frame", int'(ts_idx), 31);
    check("R7", "frame_odd end of odd frame", int'(frame_odd), 1);
    send_range(1, 1, 1, 0, 6);
    check("R5", "sync_n one bit before confirm", int'(sync_n), 1);
    send_range(1, 1, 1, 7, 7);
    check("R5", "sync_n on confirming bit", int'(sync_n), 0);
    check("R7", "frame_odd in even frame", int'(frame_odd), 0);
    send_range(1, 1, 1, 8, 255);
    // two bad, one good, two bad: count cleared, still locked
    for (int k = 0; k < 5; k++) begin
      send_range(0, 1, 1, 0, 255);
      send_range(1, (k == 2), 1, 0, 255);
    end
    check("R8", "sync_n after cleared error run", int'(sync_n), 0);
    send_range(0, 1, 1, 0, 255);
    send_range(1, 0, 1, 0, 6);
    check("R8", "sync_n before third error", int'(sync_n), 0);
    send_range(1, 0, 1, 7, 7);
    check("R8", "sync_n on third errored word", int'(sync_n), 1);
    send_range(1, 0, 1, 8, 255);

    // Scenario B: odd-frame bit 2 zero rejects the candidate; idle gaps
    gap = 1;
    do_reset();
    send_range(1, 1, 1, 0, 255);
    send_range(0, 1, 0, 0, 255);
    send_range(1, 1, 1, 0, 255);
    check("R4", "no sync after rejected candidate", int'(sync_n), 1);
    send_range(0, 1, 1, 0, 255);
    send_range(1, 1, 1, 0, 7);
    check("R4", "sync after fresh candidate", int'(sync_n), 0);
    send_range(1, 1, 1, 8, 40);
    gap = 0;

    // Scenario C: stream starts mid-frame
    do_reset();
    send_range(0, 1, 1, 100, 255);
    send_range(1, 1, 1, 0, 255);
    send_range(0, 1, 1, 0, 255);
    send_range(1, 1, 1, 0, 255);
    check("R5", "sync from mid-frame start", int'(sync_n), 0);
    check("R7", "bit_idx at frame end", int'(bit_idx), 7);
    check("R7", "ts_idx at frame end", int'(ts_idx), 31);

    @(negedge clk);
    compare_all("R7");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule